// File: doc/BRIEF.md
# Flash Read-Path Mode Multiplexer

This block produces the reply to every read of a parallel NOR flash model. A command decoder elsewhere tells it which read mode is active: plain array access, device identification, program in progress, erase in progress, or parameter-table query. The block picks the matching source for each accepted read. That source is array bytes gathered from storage, one of four identification words, the status byte, or one byte of the query table. The reply is registered and appears one cycle after the read strobe.

The block owns the status byte. An erase controller sets, clears and flips the four live status bits through separate control vectors. Reads flip the polling bits on their own, which lets software see that an operation is still busy. A third function tracks plain reads issued while no command sequence is pending. After a fixed run of such reads it signals a forced return to array mode. Any first-cycle write clears that run.

Top module: `flash_read_mux`

## Requirements
- R1: After a synchronous reset, rd_valid_o is 0, status_o is 0x00, force_array_o is 0 and array_mode_o is 1.
- R2: An accepted read (rd_en_i high at a clock edge) raises rd_valid_o with its reply after that same edge. rd_valid_o is 0 after an edge without a read.
- R3: In array mode (mode_i = 0), the read returns storage bytes. The address is first aligned down to the access size. Width select 0, 1 and 2 means 1, 2 and 4 bytes. The reply is zero-extended. With big_endian_i low, the byte at the lowest address is least significant. With it high, that byte is most significant.
- R4: In identification mode (mode_i = 1), the slot index is the low address byte shifted right by log2 of the access size. Slots 0 and 1 return id0_i and id1_i. Slot 2 returns 0. Slots other than 0, 1, 2, 14 and 15 return array data as in R3.
- R5: In identification mode, slots 14 and 15 return id2_i and id3_i. If that word's low byte is 0xFF, they return array data instead.
- R6: In program mode (mode_i = 2), each read flips status bit 6 and returns the updated status byte.
- R7: In erase mode (mode_i = 3), each read flips status bits 6 and 2 and returns the updated status byte.
- R8: In array mode with erase suspended, a read of a sector marked as erasing flips only status bit 2 and returns the updated status. A read of an unmarked sector returns array data and leaves the status unchanged.
- R9: In query mode (mode_i = 4), the slot index is driven on cfi_idx_o and the table byte is returned. Slots at or above the table depth (77) read as 0.
- R10: A read counts when no command cycle is pending and array_mode_o is 0. The 43rd counted read pulses force_array_o for one cycle and sets array_mode_o. Reads with a cycle pending are not counted.
- R11: wr0_i clears the read count and array_mode_o in the next cycle.
- R12: Status control index 3, 2, 1 and 0 maps to status bits 7, 6, 3 and 2. Set is applied first, then clear, then the control toggle, so clear beats set on the same bit. All other status bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Read mode from the command decoder |
| cyc_pending_i | input | 1 | A command sequence has started |
| suspended_i | input | 1 | Erase is suspended |
| sect_erasing_i | input | 1 | Addressed sector is marked for erase |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| width_sel_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| big_endian_i | input | 1 | Byte order of array words |
| arr_addr_o | output | ADDR_W | Aligned storage address |
| arr_bytes_i | input | 32 | Four storage bytes from arr_addr_o upward, lowest in bits 7:0 |
| id0_i | input | 16 | Identification word, slot 0 |
| id1_i | input | 16 | Identification word, slot 1 |
| id2_i | input | 16 | Identification word, slot 14 |
| id3_i | input | 16 | Identification word, slot 15 |
| cfi_idx_o | output | 8 | Query table index |
| cfi_byte_i | input | 8 | Query table byte |
| wr0_i | input | 1 | First-cycle write seen |
| st_set_i | input | 4 | Status set controls |
| st_clr_i | input | 4 | Status clear controls |
| st_tgl_i | input | 4 | Status toggle controls |
| rd_data_o | output | 32 | Registered read reply |
| rd_valid_o | output | 1 | Reply valid |
| status_o | output | 8 | Status byte |
| array_mode_o | output | 1 | Array-mode flag |
| force_array_o | output | 1 | One-cycle forced return pulse |

## Verification
Several rules hold on every cycle and are checked continuously:
- The reply valid follows the strobe with one cycle of latency.
- Program and erase reads flip the right polling bits.
- A suspended-sector read leaves bit 6 alone.
- Out-of-range query slots read zero.
- The idle-read count never passes its limit.
- A first-cycle write always clears array mode.

Other behaviour needs the bench's scenarios to show it:
- The actual reply values for each access size and byte order.
- The identification fallback when a low byte is 0xFF.
- Clear winning over set.
- The exact read that fires the forced return, and the rule that a pending-cycle read does not count.

// File: rtl/frl_pkg.sv
package frl_pkg;

    typedef enum logic [2:0] {
        RM_ARRAY   = 3'd0,
        RM_IDENT   = 3'd1,
        RM_PROGRAM = 3'd2,
        RM_ERASE   = 3'd3,
        RM_QUERY   = 3'd4
    } rd_mode_e;

    localparam int unsigned CTRL_W   = 4;
    localparam logic [7:0]  MASK_PGM = 8'h40;
    localparam logic [7:0]  MASK_ERS = 8'h44;
    localparam logic [7:0]  MASK_SUS = 8'h04;
    localparam logic [7:0]  ID_VOID  = 8'hFF;

    typedef struct packed {
        logic        use_status;
        logic [7:0]  tgl_mask;
        logic [31:0] data;
    } rd_reply_t;

    // control index 3,2,1,0 -> status bit 7,6,3,2
    function automatic logic [7:0] expand_ctrl(input logic [CTRL_W-1:0] c);
        return {c[3], c[2], 2'b00, c[1], c[0], 2'b00};
    endfunction

    function automatic logic [1:0] size_shift(input logic [1:0] w);
        case (w)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/frl_lane_pack.sv
module frl_lane_pack
    import frl_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        shift_i,
    input  logic              big_endian_i,
    input  logic [31:0]       bytes_i,
    output logic [ADDR_W-1:0] aligned_o,
    output logic [31:0]       word_o
);
    localparam int unsigned LANES = 4;

    logic [7:0] lane [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane[g] = bytes_i[8*g +: 8];
        end
    endgenerate

    always_comb begin
        aligned_o = addr_i;
        case (shift_i)
            2'd1:    aligned_o[0]   = 1'b0;
            2'd2:    aligned_o[1:0] = 2'b00;
            default: aligned_o      = addr_i;
        endcase
    end

    always_comb begin
        case (shift_i)
            2'd0:    word_o = {24'h0, lane[0]};
            2'd1:    word_o = big_endian_i ? {16'h0, lane[0], lane[1]}
                                           : {16'h0, lane[1], lane[0]};
            default: word_o = big_endian_i ? {lane[0], lane[1], lane[2], lane[3]}
                                           : {lane[3], lane[2], lane[1], lane[0]};
        endcase
    end

endmodule

// File: rtl/frl_status_reg.sv
module frl_status_reg
    import frl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] set_i,
    input  logic [CTRL_W-1:0] clr_i,
    input  logic [CTRL_W-1:0] tgl_i,
    input  logic [7:0]        rd_mask_i,
    output logic [7:0]        next_o,
    output logic [7:0]        q_o
);
    logic [7:0] q;

    always_comb begin
        next_o = ((q | expand_ctrl(set_i)) & ~expand_ctrl(clr_i))
                 ^ expand_ctrl(tgl_i) ^ rd_mask_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 8'h00;
        else     q <= next_o;
    end

    assign q_o = q;

    assert_clr_beats_set_R12: assert property (@(posedge clk) disable iff (rst)
        (clr_i[1] && !tgl_i[1]) |=> !q[3]);

    assert_dead_bits_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_mask_i & 8'h33) == 8'h00 |=> (q & 8'h33) == 8'h00);

endmodule

// File: rtl/frl_idle_counter.sv
module frl_idle_counter #(
    parameter int unsigned LIMIT = 42
) (
    input  logic clk,
    input  logic rst,
    input  logic wr0_i,
    input  logic count_i,
    output logic array_o,
    output logic force_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;
    logic             array_q;
    logic             force_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            array_q <= 1'b1;
            force_q <= 1'b0;
        end else begin
            force_q <= 1'b0;
            if (wr0_i) begin
                cnt     <= '0;
                array_q <= 1'b0;
            end else if (count_i && !array_q) begin
                if (cnt == CNT_W'(LIMIT)) begin
                    cnt     <= '0;
                    array_q <= 1'b1;
                    force_q <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign array_o = array_q;
    assign force_o = force_q;

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(LIMIT));

    assert_force_sets_flag_R10: assert property (@(posedge clk) disable iff (rst)
        force_q |-> array_q);

    assert_wr0_clears_R11: assert property (@(posedge clk) disable iff (rst)
        wr0_i |=> (!array_q && cnt == '0));

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import frl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned CFI_DEPTH  = 77,
    parameter int unsigned LAZY_LIMIT = 42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_i,
    input  logic              cyc_pending_i,
    input  logic              suspended_i,
    input  logic              sect_erasing_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [1:0]        width_sel_i,
    input  logic              big_endian_i,
    output logic [ADDR_W-1:0] arr_addr_o,
    input  logic [31:0]       arr_bytes_i,
    input  logic [15:0]       id0_i,
    input  logic [15:0]       id1_i,
    input  logic [15:0]       id2_i,
    input  logic [15:0]       id3_i,
    output logic [7:0]        cfi_idx_o,
    input  logic [7:0]        cfi_byte_i,
    input  logic              wr0_i,
    input  logic [3:0]        st_set_i,
    input  logic [3:0]        st_clr_i,
    input  logic [3:0]        st_tgl_i,
    output logic [31:0]       rd_data_o,
    output logic              rd_valid_o,
    output logic [7:0]        status_o,
    output logic              array_mode_o,
    output logic              force_array_o
);
    localparam int unsigned IDX_W = 8;

    rd_mode_e    mode;
    logic [1:0]  shift;
    logic [IDX_W-1:0] slot;
    logic [31:0] arr_word;
    rd_reply_t   reply;
    logic [7:0]  rd_mask;
    logic [7:0]  st_next;
    logic [7:0]  st_q;
    logic [31:0] data_q;
    logic        valid_q;

    assign mode  = rd_mode_e'(mode_i);
    assign shift = size_shift(width_sel_i);
    assign slot  = rd_addr_i[IDX_W-1:0] >> shift;
    assign cfi_idx_o = slot;

    frl_lane_pack #(.ADDR_W(ADDR_W)) u_pack (
        .addr_i       (rd_addr_i),
        .shift_i      (shift),
        .big_endian_i (big_endian_i),
        .bytes_i      (arr_bytes_i),
        .aligned_o    (arr_addr_o),
        .word_o       (arr_word)
    );

    always_comb begin
        reply = '{use_status: 1'b0, tgl_mask: 8'h00, data: arr_word};
        case (mode)
            RM_IDENT: begin
                case (slot)
                    8'h00: reply.data = {16'h0, id0_i};
                    8'h01: reply.data = {16'h0, id1_i};
                    8'h02: reply.data = 32'h0;
                    8'h0E: if (id2_i[7:0] != ID_VOID) reply.data = {16'h0, id2_i};
                    8'h0F: if (id3_i[7:0] != ID_VOID) reply.data = {16'h0, id3_i};
                    default: reply.data = arr_word;
                endcase
            end
            RM_PROGRAM: begin
                reply.use_status = 1'b1;
                reply.tgl_mask   = MASK_PGM;
            end
            RM_ERASE: begin
                reply.use_status = 1'b1;
                reply.tgl_mask   = MASK_ERS;
            end
            RM_QUERY: begin
                reply.data = (32'(slot) < CFI_DEPTH) ? {24'h0, cfi_byte_i} : 32'h0;
            end
            default: begin
                if (suspended_i && sect_erasing_i) begin
                    reply.use_status = 1'b1;
                    reply.tgl_mask   = MASK_SUS;
                end
            end
        endcase
    end

    assign rd_mask = rd_en_i ? reply.tgl_mask : 8'h00;

    frl_status_reg u_status (
        .clk       (clk),
        .rst       (rst),
        .set_i     (st_set_i),
        .clr_i     (st_clr_i),
        .tgl_i     (st_tgl_i),
        .rd_mask_i (rd_mask),
        .next_o    (st_next),
        .q_o       (st_q)
    );

    frl_idle_counter #(.LIMIT(LAZY_LIMIT)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .wr0_i   (wr0_i),
        .count_i (rd_en_i && !cyc_pending_i),
        .array_o (array_mode_o),
        .force_o (force_array_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= 32'h0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_en_i;
            if (rd_en_i)
                data_q <= reply.use_status ? {24'h0, st_next} : reply.data;
        end
    end

    assign rd_data_o  = data_q;
    assign rd_valid_o = valid_q;
    assign status_o   = st_q;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> rd_valid_o);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> !rd_valid_o);

    assert_prog_flip_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && mode_i == 3'd2 && st_set_i == 4'h0 && st_clr_i == 4'h0 && st_tgl_i == 4'h0)
        |=> status_o[6] != $past(status_o[6]));

    assert_erase_flip_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && mode_i == 3'd3 && st_set_i == 4'h0 && st_clr_i == 4'h0 && st_tgl_i == 4'h0)
        |=> (status_o[6] != $past(status_o[6]) && status_o[2] != $past(status_o[2])));

    assert_suspend_flip_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && mode_i == 3'd0 && suspended_i && sect_erasing_i &&
         st_set_i == 4'h0 && st_clr_i == 4'h0 && st_tgl_i == 4'h0)
        |=> (status_o[6] == $past(status_o[6]) && status_o[2] != $past(status_o[2])));

    assert_query_tail_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && mode_i == 3'd4 && 32'(rd_addr_i[7:0] >> size_shift(width_sel_i)) >= CFI_DEPTH)
        |=> rd_data_o == 32'h0);

endmodule

// File: tb/flash_read_mux_bench.sv
module flash_read_mux_bench;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned AW = 20;
    localparam int unsigned NVEC = 18;

    // {mode, width, big_endian, address, expected}
    localparam logic [63:0] VEC [NVEC] = '{
        {4'd0, 4'd0, 4'd0, 20'h00010, 32'h000000B5},
        {4'd0, 4'd1, 4'd0, 20'h00020, 32'h00008485},
        {4'd0, 4'd1, 4'd1, 20'h00020, 32'h00008584},
        {4'd0, 4'd2, 4'd0, 20'h00040, 32'hE6E7E4E5},
        {4'd0, 4'd2, 4'd1, 20'h00040, 32'hE5E4E7E6},
        {4'd0, 4'd2, 4'd0, 20'h00042, 32'hE6E7E4E5},
        {4'd1, 4'd0, 4'd0, 20'h00000, 32'h00000001},
        {4'd1, 4'd1, 4'd0, 20'h00002, 32'h0000227E},
        {4'd1, 4'd1, 4'd0, 20'h00004, 32'h00000000},
        {4'd1, 4'd1, 4'd0, 20'h0001C, 32'h00002210},
        {4'd1, 4'd1, 4'd0, 20'h0001E, 32'h0000BABB},
        {4'd1, 4'd0, 4'd0, 20'h00006, 32'h000000A3},
        {4'd1, 4'd0, 4'd0, 20'h0010E, 32'h00002210},
        {4'd4, 4'd0, 4'd0, 20'h00010, 32'h00000050},
        {4'd4, 4'd1, 4'd0, 20'h00020, 32'h00000050},
        {4'd4, 4'd0, 4'd0, 20'h0004C, 32'h0000008C},
        {4'd4, 4'd0, 4'd0, 20'h0004D, 32'h00000000},
        {4'd4, 4'd0, 4'd0, 20'h000FF, 32'h00000000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    mode = 3'd0;
    logic          pend = 1'b0, sus = 1'b0, ers = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [1:0]    wsel = 2'd0;
    logic          bend = 1'b0;
    logic [AW-1:0] arr_addr;
    logic [31:0]   arr_bytes;
    logic [7:0]    cfi_idx, cfi_byte;
    logic          wr0 = 1'b0;
    logic [3:0]    sset = '0, sclr = '0, stgl = '0;
    logic [31:0]   rd_data;
    logic          rd_valid;
    logic [7:0]    status;
    logic          amode, force_ra;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] sb(input logic [AW-1:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    assign arr_bytes = {sb(arr_addr + 3), sb(arr_addr + 2), sb(arr_addr + 1), sb(arr_addr)};
    assign cfi_byte  = cfi_idx + 8'h40;

    flash_read_mux u_flash_read_mux (
        .clk(clk), .rst(rst), .mode_i(mode), .cyc_pending_i(pend),
        .suspended_i(sus), .sect_erasing_i(ers), .rd_en_i(rd_en),
        .rd_addr_i(addr), .width_sel_i(wsel), .big_endian_i(bend),
        .arr_addr_o(arr_addr), .arr_bytes_i(arr_bytes),
        .id0_i(16'h0001), .id1_i(16'h227E), .id2_i(16'h2210), .id3_i(16'h00FF),
        .cfi_idx_o(cfi_idx), .cfi_byte_i(cfi_byte), .wr0_i(wr0),
        .st_set_i(sset), .st_clr_i(sclr), .st_tgl_i(stgl),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid), .status_o(status),
        .array_mode_o(amode), .force_array_o(force_ra)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] m, input logic [1:0] w, input logic be,
                      input logic [AW-1:0] a);
        @(negedge clk);
        mode = m; wsel = w; bend = be; addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ctl(input logic [3:0] s, input logic [3:0] c, input logic [3:0] t);
        @(negedge clk);
        sset = s; sclr = c; stgl = t;
        @(negedge clk);
        sset = '0; sclr = '0; stgl = '0;
    endtask

    task automatic pulse_wr0();
        @(negedge clk); wr0 = 1'b1;
        @(negedge clk); wr0 = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid", {31'b0, rd_valid}, 32'd0);
        chk("R1 status", {24'b0, status}, 32'h00);
        chk("R1 array_mode", {31'b0, amode}, 32'd1);
        chk("R1 force", {31'b0, force_ra}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            rd(VEC[i][62:60], VEC[i][57:56], VEC[i][52], VEC[i][51:32]);
            // R3 R4 R5 R9 reply values, R2 valid
            chk($sformatf("R3/R4/R5/R9 vec%0d", i), rd_data, VEC[i][31:0]);
            chk($sformatf("R2 valid vec%0d", i), {31'b0, rd_valid}, 32'd1);
        end
        @(negedge clk);
        chk("R2 valid drops", {31'b0, rd_valid}, 32'd0);
        chk("R8 array reads keep status", {24'b0, status}, 32'h00);
        chk("R10 no force in array mode", {31'b0, force_ra}, 32'd0);

        rd(3'd2, 2'd0, 1'b0, 20'h10);
        chk("R6 program first", rd_data, 32'h40);
        rd(3'd2, 2'd0, 1'b0, 20'h10);
        chk("R6 program second", rd_data, 32'h00);
        chk("R6 status", {24'b0, status}, 32'h00);
        rd(3'd3, 2'd0, 1'b0, 20'h10);
        chk("R7 erase first", rd_data, 32'h44);
        rd(3'd3, 2'd0, 1'b0, 20'h10);
        chk("R7 erase second", rd_data, 32'h00);

        ctl(4'b1000, 4'b0000, 4'b0000);
        chk("R12 set bit7", {24'b0, status}, 32'h80);
        ctl(4'b0010, 4'b1000, 4'b0000);
        chk("R12 set bit3 clear bit7", {24'b0, status}, 32'h08);
        ctl(4'b0001, 4'b0001, 4'b0000);
        chk("R12 clear beats set", {24'b0, status}, 32'h08);
        ctl(4'b0000, 4'b0000, 4'b0100);
        chk("R12 toggle bit6", {24'b0, status}, 32'h48);
        ctl(4'b0000, 4'b1111, 4'b0000);
        chk("R12 clear all", {24'b0, status}, 32'h00);

        sus = 1'b1; ers = 1'b1;
        rd(3'd0, 2'd0, 1'b0, 20'h10);
        chk("R8 suspended erasing reply", rd_data, 32'h04);
        chk("R8 suspended erasing status", {24'b0, status}, 32'h04);
        ers = 1'b0;
        rd(3'd0, 2'd0, 1'b0, 20'h10);
        chk("R8 other sector array", rd_data, 32'hB5);
        chk("R8 other sector status", {24'b0, status}, 32'h04);
        sus = 1'b0;

        pulse_wr0();
        chk("R11 wr0 clears array mode", {31'b0, amode}, 32'd0);
        for (int i = 0; i < 20; i++) rd(3'd0, 2'd0, 1'b0, 20'h0);
        pulse_wr0();
        for (int i = 0; i < 42; i++) rd(3'd0, 2'd0, 1'b0, 20'h0);
        chk("R11 count restarted", {31'b0, amode}, 32'd0);
        chk("R11 no force yet", {31'b0, force_ra}, 32'd0);
        pend = 1'b1;
        rd(3'd0, 2'd0, 1'b0, 20'h0);
        pend = 1'b0;
        chk("R10 pending read not counted", {31'b0, force_ra}, 32'd0);
        rd(3'd0, 2'd0, 1'b0, 20'h0);
        chk("R10 force on 43rd", {31'b0, force_ra}, 32'd1);
        chk("R10 array mode set", {31'b0, amode}, 32'd1);
        @(negedge clk);
        chk("R10 force one cycle", {31'b0, force_ra}, 32'd0);
        rd(3'd0, 2'd0, 1'b0, 20'h0);
        chk("R10 no recount in array mode", {31'b0, force_ra}, 32'd0);

        finish_run();
    end

endmodule